// File: doc/BRIEF.md
# Charge Pump Switch Phase Sequencer

This block times the seven switch commands of a negative charge pump. The pump has two flying capacitors in a series-parallel arrangement. The sequencer does not use a plain two-phase non-overlapping clock. It steps through a ring of six timed phases:

- an all-open dead time;
- a parallel charge phase;
- a first break;
- a short link phase, in which the capacitors are joined in series one node at a time;
- a second break, in which only the middle switch stays closed;
- the transfer to the output.

Because of this ordering, the middle switch S4 is always closed before the ground-pull switch S1 and the output switch S7 close. It also means that no two conflicting switches ever conduct in the same cycle.

Each phase lasts a number of clock cycles taken from its own 8-bit duration input. A synchronous reset opens every switch on the next edge, and so does dropping the enable. When the enable returns, the ring restarts from the dead-time phase. Every switch enable and the phase code come straight from flip-flops. Level shifting, gate drive and output regulation belong to other blocks.

Top module: `pump_phase_seq`

## Requirements
- R1: `swEn` bit i drives switch S(i+1), and a 1 closes it. The closed switches for each phase code are:
  - phase 1: S2, S3, S5, S6 (`7'b0110110`)
  - phase 2: S2, S3 (`7'b0000110`)
  - phase 3: S2, S3, S4 (`7'b0001110`)
  - phase 4: S4 (`7'b0001000`)
  - phase 5: S1, S4, S7 (`7'b1001001`)
  - phases 0 and 6: none
- R2: While enabled, `phase` follows the ring 6, 1, 2, 3, 4, 5, 6, 1, and so on.
- R3: A phase lasts the number of cycles on its duration input. The inputs map to phases as follows: `durDead` to 6, `durCharge` to 1, `durBreakA` to 2, `durLink` to 3, `durBreakB` to 4 and `durTransfer` to 5. A duration of 0 lasts one cycle.
- R4: Any clock edge that samples `enable` low sets `swEn` to 0 and `phase` to 0. Both stay there while `enable` is low.
- R5: Any clock edge that samples `rst` high sets `swEn` to 0 and `phase` to 0.
- R6: The first edge that samples `enable` high while the phase is 0 starts phase 6, with all switches open. Phase 6 lasts the `durDead` cycles.
- R7: S1 or S7 is never closed in the same cycle as any of S2, S3, S5 or S6, and S4 is never closed in the same cycle as S5 or S6.
- R8: S1 closes only in a cycle directly after one in which S4 was already closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the sequence while high |
| durDead | input | 8 | Cycles of the all-open phase 6 |
| durCharge | input | 8 | Cycles of the parallel charge phase 1 |
| durBreakA | input | 8 | Cycles of the first break, phase 2 |
| durLink | input | 8 | Cycles of the series link phase 3 |
| durBreakB | input | 8 | Cycles of the second break, phase 4 |
| durTransfer | input | 8 | Cycles of the output transfer phase 5 |
| swEn | output | 7 | Registered switch enables, bit i for S(i+1) |
| phase | output | 3 | Registered current phase code |

## Verification
Both outputs change on the first clock edge that samples a change of `enable` or `rst`. The bench therefore counts sample index 0 as the falling edge right after the edge that took in the new enable, and reads every output on falling edges. From there it derives the expected phase arithmetically, as the sample index modulo the sum of the saturated durations. It does this over several duration sets, including all-zero and all-one sets, and it expects idle outputs one falling edge after a disable or a reset. Exclusion and S4-first ordering are checked on every sampled cycle from the observed outputs alone.

// File: rtl/pump_seq_pkg.sv
package pump_seq_pkg;

  localparam int NUM_SW = 7;
  localparam int NUM_TIMED = 6;

  typedef enum logic [2:0] {
    PH_OFF     = 3'd0,
    PH_CHARGE  = 3'd1,
    PH_BREAK_A = 3'd2,
    PH_LINK    = 3'd3,
    PH_BREAK_B = 3'd4,
    PH_XFER    = 3'd5,
    PH_DEAD    = 3'd6
  } phase_e;

  // Strobes from control to the duration datapath
  typedef struct packed {
    logic   loadTimer;
    phase_e target;
  } seq_strobe_t;

  // Closed switches per phase, bit i = switch i+1
  function automatic logic [NUM_SW-1:0] switchMap(phase_e p);
    case (p)
      PH_CHARGE:  return 7'b0110110;
      PH_BREAK_A: return 7'b0000110;
      PH_LINK:    return 7'b0001110;
      PH_BREAK_B: return 7'b0001000;
      PH_XFER:    return 7'b1001001;
      default:    return '0;
    endcase
  endfunction

  function automatic phase_e successor(phase_e p);
    case (p)
      PH_DEAD:    return PH_CHARGE;
      PH_CHARGE:  return PH_BREAK_A;
      PH_BREAK_A: return PH_LINK;
      PH_LINK:    return PH_BREAK_B;
      PH_BREAK_B: return PH_XFER;
      PH_XFER:    return PH_DEAD;
      default:    return PH_OFF;
    endcase
  endfunction

endpackage

// File: rtl/pump_seq_timer.sv
module pump_seq_timer
  import pump_seq_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  seq_strobe_t                      strobe,
  input  logic [NUM_TIMED-1:0][DUR_W-1:0]  durTable,
  output logic                             expired
);

  logic [DUR_W-1:0] count;
  logic [DUR_W-1:0] selDur;
  logic [DUR_W-1:0] loadVal;

  // durTable index = phase code - 1
  always_comb begin
    case (strobe.target)
      PH_CHARGE:  selDur = durTable[0];
      PH_BREAK_A: selDur = durTable[1];
      PH_LINK:    selDur = durTable[2];
      PH_BREAK_B: selDur = durTable[3];
      PH_XFER:    selDur = durTable[4];
      PH_DEAD:    selDur = durTable[5];
      default:    selDur = '0;
    endcase
    // zero saturates to a one-cycle phase
    loadVal = (selDur == '0) ? '0 : selDur - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (strobe.loadTimer) count <= loadVal;
    else if (count != '0) count <= count - 1'b1;
  end

  assign expired = (count == '0);

endmodule

// File: rtl/pump_seq_ctrl.sv
module pump_seq_ctrl
  import pump_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              expired,
  output seq_strobe_t       strobe,
  output logic [NUM_SW-1:0] swEn,
  output logic [2:0]        phase
);

  phase_e state;
  phase_e nextState;
  logic   loadNow;

  always_comb begin
    nextState = state;
    loadNow   = 1'b0;
    if (!enable) begin
      nextState = PH_OFF;
    end else if (state == PH_OFF) begin
      nextState = PH_DEAD;
      loadNow   = 1'b1;
    end else if (expired) begin
      nextState = successor(state);
      loadNow   = 1'b1;
    end
  end

  assign strobe.loadTimer = loadNow;
  assign strobe.target    = nextState;

  // Outputs are flops loaded from the next-state decode
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PH_OFF;
      swEn  <= '0;
    end else begin
      state <= nextState;
      swEn  <= switchMap(nextState);
    end
  end

  assign phase = state;

endmodule

// File: rtl/pump_phase_seq.sv
module pump_phase_seq
  import pump_seq_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [DUR_W-1:0] durDead,
  input  logic [DUR_W-1:0] durCharge,
  input  logic [DUR_W-1:0] durBreakA,
  input  logic [DUR_W-1:0] durLink,
  input  logic [DUR_W-1:0] durBreakB,
  input  logic [DUR_W-1:0] durTransfer,
  output logic [6:0]       swEn,
  output logic [2:0]       phase
);

  seq_strobe_t                     strobe;
  logic                            expired;
  logic [NUM_TIMED-1:0][DUR_W-1:0] durTable;

  assign durTable = {durDead, durTransfer, durBreakB, durLink, durBreakA, durCharge};

  pump_seq_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .expired (expired),
    .strobe  (strobe),
    .swEn    (swEn),
    .phase   (phase)
  );

  pump_seq_timer #(.DUR_W(DUR_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .durTable (durTable),
    .expired  (expired)
  );

endmodule

// File: rtl/pump_seq_checker.sv
module pump_seq_checker (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic [6:0] swEn,
  input logic [2:0] phase
);

  // R7: ground/output switches never with charge switches
  assert_no_cross_conduct_R7: assert property (@(posedge clk) disable iff (rst)
    !((swEn[0] | swEn[6]) & (swEn[1] | swEn[2] | swEn[4] | swEn[5])));

  // R7: middle switch never with the second capacitor's charge switches
  assert_mid_isolated_R7: assert property (@(posedge clk) disable iff (rst)
    !(swEn[3] & (swEn[4] | swEn[5])));

  // R8: S4 closed in the cycle before S1 closes
  assert_mid_before_ground_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(swEn[0]) |-> $past(swEn[3]));

  // R2: transfer only entered from the second break
  assert_xfer_after_break_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(swEn[6]) |-> ($past(phase) == 3'd4));

  // R2: charge only entered from all-open dead time
  assert_charge_after_dead_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(swEn[4]) |-> ($past(swEn) == 7'd0));

  // R4: disable opens everything on the next edge
  assert_disable_opens_R4: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (swEn == 7'd0 && phase == 3'd0));

  // R5: reset opens everything on the next edge
  assert_reset_opens_R5: assert property (@(posedge clk)
    rst |=> (swEn == 7'd0 && phase == 3'd0));

  // R2: phase code stays in the legal set
  assert_phase_legal_R2: assert property (@(posedge clk) disable iff (rst)
    phase != 3'd7);

endmodule

bind pump_phase_seq pump_seq_checker chk_i (
  .clk    (clk),
  .rst    (rst),
  .enable (enable),
  .swEn   (swEn),
  .phase  (phase)
);

// File: tb/pump_phase_seq_tb.sv
`timescale 1ns/1ps
module pump_phase_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic [7:0] durDead = 8'd0, durCharge = 8'd0, durBreakA = 8'd0;
  logic [7:0] durLink = 8'd0, durBreakB = 8'd0, durTransfer = 8'd0;
  logic [6:0] swEn;
  logic [2:0] phase;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int dd[6];             // saturated durations in ring order: 6,1,2,3,4,5
  int ringCode[6] = '{6, 1, 2, 3, 4, 5};

  always #2.5 clk = ~clk;   // 200 MHz

  pump_phase_seq dut_i (
    .clk(clk), .rst(rst), .enable(enable),
    .durDead(durDead), .durCharge(durCharge), .durBreakA(durBreakA),
    .durLink(durLink), .durBreakB(durBreakB), .durTransfer(durTransfer),
    .swEn(swEn), .phase(phase)
  );

  function automatic logic [6:0] expMap(int p);
    case (p)
      1: return 7'b0110110;
      2: return 7'b0000110;
      3: return 7'b0001110;
      4: return 7'b0001000;
      5: return 7'b1001001;
      default: return 7'b0;
    endcase
  endfunction

  function automatic int satDur(logic [7:0] d);
    return (d == 8'd0) ? 1 : int'(d);
  endfunction

  function automatic int ringPhase(int o);
    int acc = 0;
    for (int i = 0; i < 6; i++) begin
      acc += dd[i];
      if (o < acc) return ringCode[i];
    end
    return 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic setDurs(int a, int b, int c, int d, int e, int f);
    durDead = 8'(a); durCharge = 8'(b); durBreakA = 8'(c);
    durLink = 8'(d); durBreakB = 8'(e); durTransfer = 8'(f);
    dd[0] = satDur(durDead);  dd[1] = satDur(durCharge); dd[2] = satDur(durBreakA);
    dd[3] = satDur(durLink);  dd[4] = satDur(durBreakB); dd[5] = satDur(durTransfer);
  endtask

  // Called right after the edge that first sampled enable high (or rst released)
  task automatic runRing(int n);
    int period = dd[0] + dd[1] + dd[2] + dd[3] + dd[4] + dd[5];
    logic [6:0] prev = 7'b0;
    for (int k = 0; k < n; k++) begin
      int o;
      int ep;
      @(negedge clk);
      o  = k % period;
      ep = ringPhase(o);
      if (k < dd[0]) check(phase == 3'(ep), "R6 dead phase first", phase, ep);
      else check(phase == 3'(ep), "R2 R3 phase order/length", phase, ep);
      check(swEn == expMap(ep), "R1 switch map", swEn, expMap(ep));
      check(!((swEn[0] | swEn[6]) & (swEn[1] | swEn[2] | swEn[4] | swEn[5]))
            && !(swEn[3] & (swEn[4] | swEn[5])), "R7 exclusion", swEn, 0);
      if (swEn[0] && !prev[0]) check(prev[3], "R8 S4 before S1", prev, 7'b0001000);
      prev = swEn;
    end
  endtask

  task automatic expectIdle(string req, int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      check(swEn == 7'b0 && phase == 3'd0, req, {phase, swEn}, 0);
    end
  endtask

  task automatic runConfig(int a, int b, int c, int d, int e, int f, int extra);
    int period;
    setDurs(a, b, c, d, e, f);
    period = dd[0] + dd[1] + dd[2] + dd[3] + dd[4] + dd[5];
    enable = 1'b1;
    runRing(2 * period + extra);
    enable = 1'b0;
    expectIdle("R4 disable opens all", 3);
  endtask

  initial begin
    setDurs(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check(swEn == 7'b0 && phase == 3'd0, "R5 reset state", {phase, swEn}, 0);
    rst = 1'b0;
    expectIdle("R4 idle while enable low", 3);

    runConfig(0, 0, 0, 0, 0, 0, 1);
    runConfig(1, 1, 1, 1, 1, 1, 2);
    runConfig(3, 5, 2, 1, 2, 5, 3);
    runConfig(0, 4, 0, 1, 0, 4, 5);
    runConfig(2, 10, 1, 2, 1, 7, 7);
    runConfig(1, 20, 3, 0, 3, 20, 11);

    // Reset during operation, enable held high
    setDurs(2, 6, 1, 1, 1, 6);
    enable = 1'b1;
    runRing(9);
    rst = 1'b1;
    @(negedge clk);
    check(swEn == 7'b0 && phase == 3'd0, "R5 reset mid-run", {phase, swEn}, 0);
    rst = 1'b0;
    runRing(40);
    enable = 1'b0;
    expectIdle("R4 final disable", 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule